// File: doc/BRIEF.md
# Rotating Eight-Level Interrupt Priority Resolver

This block is the decision core of an eight-level interrupt controller. Each request line is edge-sensitive. A rising edge sets a bit in the pending register. The resolver then picks the pending, unmasked level that ranks highest under the current priority ring. An interrupt is raised only when that level outranks every level now being serviced. An acknowledge strobe moves the chosen level from pending into service.

A byte-wide write port with one address bit carries two kinds of write. Address 1 loads the mask. Address 0, with bits 4:3 at zero, carries the service/rotation command. Bits 7:5 of that command select one of eight actions, and bits 2:0 name a level where the action needs one. The actions can end service (non-specific or specific), rotate the priority ring, set the lowest-priority level directly, or arm an automatic end-of-service mode that rotates on each acknowledge. The auto mode also needs the `auto_eoi_en` configuration input to be high.

Top module: `irq_rotor`

## Requirements
- R1: After reset the pending, in-service and mask registers are all zero and `irq_o` is low; level 0 ranks highest and level 7 lowest.
- R2: A rising edge on `req_i[n]` sets pending bit n. A line held high does not set it again after it is acknowledged.
- R3: Among several pending, unmasked levels, `irq_level_o` shows the one that ranks highest in the current ring.
- R4: `ack` while `irq_o` is high clears the reported level's pending bit and sets its in-service bit. `ack` while `irq_o` is low changes nothing.
- R5: `irq_o` is high only when the best pending level ranks strictly above every in-service level. Equal or lower levels stay pending.
- R6: A write with `wr_addr`=1 loads the mask from `wr_data`. A masked level cannot raise `irq_o`, and its pending bit is kept.
- R7: A write with `wr_addr`=0 is a command only when `wr_data[4:3]`=00. Other values of those bits leave every register unchanged.
- R8: Command code 001 (`wr_data[7:5]`) clears the in-service bit that ranks highest. If nothing is in service it does nothing.
- R9: Code 011 clears the in-service bit of the level in `wr_data[2:0]`. If that level is not in service, nothing changes.
- R10: Code 101 clears the highest-ranked in-service bit and makes that level the lowest priority. The next level up (modulo 8) becomes the highest.
- R11: Code 110 makes the level in `wr_data[2:0]` the lowest priority and changes no in-service bit. Naming level 7 wraps, so level 0 becomes the highest.
- R12: Code 111 clears the in-service bit of the named level and makes that level the lowest priority.
- R13: Codes 000, 010 and 100 change no in-service bit. Code 100 sets the auto-rotate flag and 000 clears it. While the flag and `auto_eoi_en` are both high, an acknowledge clears the pending bit, sets no in-service bit, and makes the acknowledged level the lowest priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Request lines, rising-edge sensitive |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 1 | 0 = command, 1 = mask |
| wr_data | input | 8 | Write data |
| auto_eoi_en | input | 1 | Configuration enable for automatic end of service |
| ack | input | 1 | Interrupt acknowledge strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_level_o | output | 3 | Level that would be acknowledged |
| isr_o | output | 8 | In-service bits |
| irr_o | output | 8 | Pending request bits |

## Verification
The hardest state to reach is a rotated ring in which a numerically lower level ranks below one already in service. This needs a rotate-on-service command first and then fresh rising edges on two chosen lines. The stimulus lowers all request lines, rotates with code 101, raises levels 0 and 6 together, and checks that level 0 is held back behind level 6. Wrap-around uses set-priority on level 7. The auto-rotate path is shown by raising levels 0 and 1 after an automatic acknowledge of level 0, so that level 1 must now win.

// File: rtl/irq_rotor_pkg.sv
package irq_rotor_pkg;
   localparam int CMD_BYTE_W = 8;
   localparam int CMD_LVL_W  = 3;

   typedef enum logic [2:0] {
      OP_AUTO_CLR = 3'b000,
      OP_EOI_ANY  = 3'b001,
      OP_IDLE     = 3'b010,
      OP_EOI_ONE  = 3'b011,
      OP_AUTO_SET = 3'b100,
      OP_ROT_ANY  = 3'b101,
      OP_LOW_SET  = 3'b110,
      OP_ROT_ONE  = 3'b111
   } op_e;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
   parameter int N           = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_i,
   input  logic [N-1:0] take_i,
   output logic [N-1:0] pend_o
);
   logic [N-1:0] req_s;
   logic [N-1:0] req_d;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign req_s = req_i;
      end else begin : g_sync
         logic [N-1:0] chain [SYNC_STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int s = 0; s < SYNC_STAGES; s++) chain[s] <= '0;
            end else begin
               chain[0] <= req_i;
               for (int s = 1; s < SYNC_STAGES; s++) chain[s] <= chain[s-1];
            end
         end
         assign req_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_d  <= '0;
         pend_o <= '0;
      end else begin
         req_d  <= req_s;
         pend_o <= (pend_o & ~take_i) | (req_s & ~req_d);
      end
   end
endmodule

// File: rtl/irq_rot_pick.sv
module irq_rot_pick #(
   parameter int N = 8,
   localparam int W = $clog2(N)
) (
   input  logic [N-1:0] vec_i,
   input  logic [W-1:0] top_i,
   output logic         hit_o,
   output logic [W-1:0] lvl_o,
   output logic [W-1:0] rank_o
);
   always_comb begin
      hit_o  = 1'b0;
      lvl_o  = '0;
      rank_o = '0;
      for (int j = N - 1; j >= 0; j--) begin
         logic [W-1:0] idx;
         idx = top_i + W'(j);
         if (vec_i[idx]) begin
            hit_o  = 1'b1;
            lvl_o  = idx;
            rank_o = W'(j);
         end
      end
   end
endmodule

// File: rtl/irq_cmd_dec.sv
module irq_cmd_dec
   import irq_rotor_pkg::*;
(
   input  logic                  wr_en,
   input  logic                  wr_addr,
   input  logic [CMD_BYTE_W-1:0] wr_data,
   output logic                  mask_we_o,
   output logic                  eoi_any_o,
   output logic                  eoi_one_o,
   output logic                  rot_o,
   output logic                  rot_named_o,
   output logic                  auto_we_o,
   output logic                  auto_val_o,
   output logic [CMD_LVL_W-1:0]  lvl_o
);
   logic cmd_hit;
   op_e  op;

   assign cmd_hit   = wr_en && !wr_addr && (wr_data[4:3] == 2'b00);
   assign mask_we_o = wr_en && wr_addr;
   assign op        = op_e'(wr_data[7:5]);
   assign lvl_o     = wr_data[CMD_LVL_W-1:0];

   always_comb begin
      eoi_any_o   = 1'b0;
      eoi_one_o   = 1'b0;
      rot_o       = 1'b0;
      rot_named_o = 1'b0;
      auto_we_o   = 1'b0;
      auto_val_o  = 1'b0;
      if (cmd_hit) begin
         unique case (op)
            OP_AUTO_CLR: auto_we_o = 1'b1;
            OP_EOI_ANY:  eoi_any_o = 1'b1;
            OP_IDLE:     ;
            OP_EOI_ONE:  eoi_one_o = 1'b1;
            OP_AUTO_SET: begin auto_we_o = 1'b1; auto_val_o = 1'b1; end
            OP_ROT_ANY:  begin eoi_any_o = 1'b1; rot_o = 1'b1; end
            OP_LOW_SET:  begin rot_o = 1'b1; rot_named_o = 1'b1; end
            OP_ROT_ONE:  begin eoi_one_o = 1'b1; rot_o = 1'b1; rot_named_o = 1'b1; end
            default:     ;
         endcase
      end
   end
endmodule

// File: rtl/irq_rotor.sv
module irq_rotor
   import irq_rotor_pkg::*;
#(
   parameter int NUM_LEVELS  = 8,
   parameter int SYNC_STAGES = 0,
   localparam int LW = $clog2(NUM_LEVELS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LEVELS-1:0] req_i,
   input  logic                  wr_en,
   input  logic                  wr_addr,
   input  logic [CMD_BYTE_W-1:0] wr_data,
   input  logic                  auto_eoi_en,
   input  logic                  ack,
   output logic                  irq_o,
   output logic [LW-1:0]         irq_level_o,
   output logic [NUM_LEVELS-1:0] isr_o,
   output logic [NUM_LEVELS-1:0] irr_o
);
   generate
      if (NUM_LEVELS != (1 << CMD_LVL_W)) begin : g_bad_levels
         $error("NUM_LEVELS must match the 3-bit level field of the command");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic [NUM_LEVELS-1:0] isr_q, imr_q, take, clr, pend;
   logic [LW-1:0]         low_q, top;
   logic                  rot_auto_q, auto_active;
   logic                  mask_we, eoi_any, eoi_one, rot, rot_named, auto_we, auto_val;
   logic [LW-1:0]         cmd_lvl;
   logic                  req_hit, svc_hit;
   logic [LW-1:0]         req_lvl, req_rank, svc_lvl, svc_rank;

   irq_cmd_dec u_dec (
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .mask_we_o(mask_we), .eoi_any_o(eoi_any), .eoi_one_o(eoi_one),
      .rot_o(rot), .rot_named_o(rot_named), .auto_we_o(auto_we),
      .auto_val_o(auto_val), .lvl_o(cmd_lvl)
   );

   irq_req_latch #(.N(NUM_LEVELS), .SYNC_STAGES(SYNC_STAGES)) u_latch (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .take_i(take), .pend_o(pend)
   );

   assign top = low_q + LW'(1);

   irq_rot_pick #(.N(NUM_LEVELS)) u_pick_req (
      .vec_i(pend & ~imr_q), .top_i(top),
      .hit_o(req_hit), .lvl_o(req_lvl), .rank_o(req_rank)
   );

   irq_rot_pick #(.N(NUM_LEVELS)) u_pick_svc (
      .vec_i(isr_q), .top_i(top),
      .hit_o(svc_hit), .lvl_o(svc_lvl), .rank_o(svc_rank)
   );

   assign irq_o       = req_hit && (!svc_hit || (req_rank < svc_rank));
   assign irq_level_o = req_lvl;
   assign auto_active = auto_eoi_en && rot_auto_q;
   assign take        = (ack && irq_o) ? (NUM_LEVELS'(1) << req_lvl) : '0;

   always_comb begin
      clr = '0;
      if (eoi_any && svc_hit) clr = NUM_LEVELS'(1) << svc_lvl;
      if (eoi_one)            clr = NUM_LEVELS'(1) << cmd_lvl;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isr_q      <= '0;
         imr_q      <= '0;
         low_q      <= LW'(NUM_LEVELS - 1);
         rot_auto_q <= 1'b0;
      end else begin
         isr_q <= (isr_q & ~clr) | (auto_active ? '0 : take);
         if (mask_we) imr_q <= wr_data[NUM_LEVELS-1:0];
         if (auto_we) rot_auto_q <= auto_val;
         if (rot && rot_named)           low_q <= cmd_lvl;
         else if (rot && svc_hit)        low_q <= svc_lvl;
         else if (!rot && auto_active && (take != '0)) low_q <= req_lvl;
      end
   end

   assign isr_o = isr_q;
   assign irr_o = pend;
endmodule

// File: rtl/irq_rotor_chk.sv
module irq_rotor_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       wr_addr,
   input logic [7:0] wr_data,
   input logic       ack,
   input logic       auto_active,
   input logic       irq_o,
   input logic [2:0] irq_level_o,
   input logic [7:0] isr_o,
   input logic [7:0] irr_o
);
   // R4: a normal acknowledge puts the reported level into service
   p_ack_enters_service_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq_o && !auto_active && !wr_en) |=> isr_o[$past(irq_level_o)]);

   // R4: at most one level enters service per cycle
   p_one_entry_per_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(isr_o) <= $past($countones(isr_o)) + 1);

   // R5: an interrupt is only raised for a pending level
   p_irq_needs_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> irr_o[irq_level_o]);

   // R9: specific end of service on an idle level changes nothing
   p_seoi_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr && wr_data[7:3] == 5'b01100 && !isr_o[wr_data[2:0]] && !ack)
      |=> $stable(isr_o));

   // R13: the idle command leaves service bits untouched
   p_idle_cmd_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr && wr_data[7:3] == 5'b01000 && !ack) |=> $stable(isr_o));

   // R13: automatic mode never leaves the acknowledged level in service
   p_auto_skips_service_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq_o && auto_active && !wr_en) |=> !isr_o[$past(irq_level_o)]);
endmodule

bind irq_rotor irq_rotor_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .ack(ack), .auto_active(auto_active), .irq_o(irq_o), .irq_level_o(irq_level_o),
   .isr_o(isr_o), .irr_o(irr_o)
);

// File: tb/irq_rotor_bench.sv
module irq_rotor_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req_i = '0;
   logic       wr_en = 1'b0;
   logic       wr_addr = 1'b0;
   logic [7:0] wr_data = '0;
   logic       auto_eoi_en = 1'b0;
   logic       ack = 1'b0;
   logic       irq_o;
   logic [2:0] irq_level_o;
   logic [7:0] isr_o, irr_o;

   int n_total = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   typedef struct {
      string      tag;
      logic       irq;
      logic [2:0] lvl;
      logic [7:0] isr;
      logic [7:0] irr;
   } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;

   irq_rotor u_irq_rotor (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .auto_eoi_en(auto_eoi_en), .ack(ack), .irq_o(irq_o),
      .irq_level_o(irq_level_o), .isr_o(isr_o), .irr_o(irr_o)
   );

   // monitor: pops expected items and compares with the ports
   initial begin
      forever begin
         @(negedge clk);
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_total++;
            if (irq_o !== e.irq || isr_o !== e.isr || irr_o !== e.irr ||
                (e.irq && irq_level_o !== e.lvl)) begin
               n_fail++;
               $display("FAIL %s: got irq=%b lvl=%0d isr=%h irr=%h, expected irq=%b lvl=%0d isr=%h irr=%h",
                        e.tag, irq_o, irq_level_o, isr_o, irr_o, e.irq, e.lvl, e.isr, e.irr);
            end
         end
      end
   end

   task automatic expect_st(string tag, logic irq, logic [2:0] lvl, logic [7:0] isr, logic [7:0] irr);
      exp_t e;
      e.tag = tag; e.irq = irq; e.lvl = lvl; e.isr = isr; e.irr = irr;
      sb.push_back(e);
      while (sb.size() != 0) @(negedge clk);
   endtask

   task automatic wr(logic a, logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic cmd(logic [2:0] code, logic [2:0] lvl);
      wr(1'b0, {code, 2'b00, lvl});
   endtask

   task automatic pulse_ack();
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
   endtask

   task automatic drive_req(logic [7:0] v);
      @(negedge clk); req_i = v;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_total++; n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      expect_st("R1 reset state", 0, 0, 8'h00, 8'h00);
      drive_req(8'h24);
      expect_st("R2 R3 edges on 2 and 5, level 2 wins", 1, 2, 8'h00, 8'h24);
      pulse_ack();
      expect_st("R4 R5 ack level 2, level 5 held", 0, 0, 8'h04, 8'h20);
      drive_req(8'h25);
      expect_st("R5 level 0 outranks service on 2", 1, 0, 8'h04, 8'h21);
      pulse_ack();
      expect_st("R4 ack level 0 nests", 0, 0, 8'h05, 8'h20);
      pulse_ack();
      expect_st("R4 ack with no irq ignored", 0, 0, 8'h05, 8'h20);
      wr(1'b0, 8'h28);
      expect_st("R7 bits 4:3 nonzero ignored", 0, 0, 8'h05, 8'h20);
      cmd(3'b001, 3'd0);
      expect_st("R8 non-specific clears level 0", 0, 0, 8'h04, 8'h20);
      cmd(3'b011, 3'd6);
      expect_st("R9 specific on idle level 6 no effect", 0, 0, 8'h04, 8'h20);
      cmd(3'b011, 3'd2);
      expect_st("R9 specific clears level 2", 1, 5, 8'h00, 8'h20);
      wr(1'b1, 8'h20);
      expect_st("R6 mask level 5", 0, 0, 8'h00, 8'h20);
      wr(1'b1, 8'h00);
      expect_st("R6 unmask level 5", 1, 5, 8'h00, 8'h20);
      pulse_ack();
      expect_st("R2 held line not re-latched", 0, 0, 8'h20, 8'h00);
      cmd(3'b010, 3'd5);
      expect_st("R13 idle code keeps service", 0, 0, 8'h20, 8'h00);
      cmd(3'b101, 3'd0);
      expect_st("R10 rotate non-specific clears 5", 0, 0, 8'h00, 8'h00);
      drive_req(8'h00);
      drive_req(8'h41);
      expect_st("R10 level 6 now highest", 1, 6, 8'h00, 8'h41);
      pulse_ack();
      expect_st("R5 R10 level 0 ranks below 6", 0, 0, 8'h40, 8'h01);
      cmd(3'b110, 3'd7);
      expect_st("R11 set lowest 7 wraps to 0 highest", 1, 0, 8'h40, 8'h01);
      cmd(3'b111, 3'd6);
      expect_st("R12 rotate specific clears 6", 1, 0, 8'h00, 8'h01);
      auto_eoi_en = 1'b1;
      cmd(3'b100, 3'd3);
      expect_st("R13 auto set keeps service", 1, 0, 8'h00, 8'h01);
      pulse_ack();
      expect_st("R13 auto ack leaves no service", 0, 0, 8'h00, 8'h00);
      drive_req(8'h00);
      drive_req(8'h03);
      expect_st("R13 auto ack rotated, level 1 highest", 1, 1, 8'h00, 8'h03);
      cmd(3'b000, 3'd0);
      pulse_ack();
      expect_st("R13 auto cleared, normal service of 1", 0, 0, 8'h02, 8'h01);
      cmd(3'b001, 3'd0);
      expect_st("R8 clears 1, level 0 lowest but raised", 1, 0, 8'h00, 8'h01);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule